// File: doc/BRIEF.md
# Cascaded Three-Group Interrupt Controller

This block collects 24 level-sensitive interrupt request lines and reports the most urgent one to a processor. The lines are split into three groups of eight. Each group is a slave stage with its own 8-bit mask and its own command port. The three slaves feed three inputs of a master stage, which has its own mask and command port as well. A byte-wide write bus reaches all eight registers.

The controller raises a single interrupt output and presents a vector that names the winning line. The vector is a bit-indexed offset: 0x800 plus sixteen times the global line number. When the processor takes the interrupt, it pulses an acknowledge input. The line then becomes in service in its group, and its cascade input becomes in service in the master. Software retires it with two specific end-of-interrupt writes, the first to the slave and the second to the master.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset every mask register (all three groups and the master) holds 0xFF and no line is in service, so `irq_out` is 0 and `irq_vector` is 0 even while all request lines are high.
- R2: Mask bit k set to 1 disables line k of that stage. The group mask registers are at byte address 0x3 (lines 0-7), 0x7 (lines 8-15) and 0x9 (lines 16-23), and bit k of each covers line 8·g+k. The master mask is at address 0x1.
- R3: Among the lines that are requesting, unmasked and not blocked, the lowest global line number wins.
- R4: While `irq_out` is 1, `irq_vector` equals 0x800 + 16·line. While `irq_out` is 0, `irq_vector` is 0.
- R5: A pulse on `int_ack` while `irq_out` is 1 puts the presented line in service in its group. That line and every higher-numbered line in the same group are then blocked.
- R6: The acknowledge also puts the group's cascade input in service in the master. Group 0 uses master input 1, group 1 uses input 3 and group 2 uses input 4. An in-service master input blocks itself and every higher-numbered input, so an interrupt from a lower-numbered group can still nest above it.
- R7: Writing a byte whose upper five bits are 11100 to a command port clears the in-service bit named by its low three bits. The group command ports are at addresses 0x2, 0x6 and 0x8, and the master command port is at 0x0. A command byte with any other upper bits has no effect. A slave end-of-interrupt alone does not release the master.
- R8: Writing 0x44 to the master mask opens all three cascade inputs. Writing 0xFF to the master mask silences every line.
- R9: Requests are level-sensitive and are not latched. When a line drops, it stops being reported.
- R10: A change on the request lines appears at the outputs after one rising clock edge. A mask write, command write or acknowledge changes the outputs after two rising edges.
- R11: A write to any address outside the eight mapped ones changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Write data |
| irq_lines | input | 24 | Level-sensitive request lines |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_vector | output | 12 | Vector of the winning line |

## Verification
The outputs are registered after the priority logic. A request change therefore shows after one rising edge. Writes and acknowledges first update a state register, so they show after two edges.

The bench drives inputs on falling edges. Each register write or acknowledge task waits two rising edges before it returns, and every comparison against the bench model is then made on a falling edge. Two directed cases pin down the timing exactly. One samples one edge after a request rises. The other samples both one edge and two edges after a mask write, so that the old value and the new value are each checked in the cycle where they are due.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int GRP_W     = 8;
  localparam int NUM_GRP   = 3;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int VEC_W     = 12;
  localparam int VEC_SHIFT = 4;
  localparam int IDX_W     = $clog2(GRP_W);
  localparam int LINES     = NUM_GRP * GRP_W;
  localparam int LINE_W    = $clog2(LINES);
  localparam logic [VEC_W-1:0] VEC_BASE = 12'h800;
  localparam logic [4:0] EOI_TAG = 5'b11100;
  localparam logic [ADDR_W-1:0] MST_CMD_A  = 4'h0;
  localparam logic [ADDR_W-1:0] MST_MASK_A = 4'h1;

  function automatic logic [ADDR_W-1:0] grp_cmd_addr(input int g);
    case (g)
      0:       return 4'h2;
      1:       return 4'h6;
      default: return 4'h8;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] grp_mask_addr(input int g);
    return grp_cmd_addr(g) + 4'h1;
  endfunction

  function automatic logic [IDX_W-1:0] casc_input(input int g);
    case (g)
      0:       return 3'd1;
      1:       return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cic_stage.sv
module cic_stage
  import cic_pkg::*;
#(
  parameter int W  = GRP_W,
  localparam int IW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      req,
  input  logic              mask_we,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_we,
  input  logic [IW-1:0]     set_idx,
  output logic              hit,
  output logic [IW-1:0]     hit_idx
);
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] isr_q, isr_d;
  logic         isr_en;
  logic [W-1:0] blocked;
  logic [W-1:0] elig;

  always_comb begin
    mask_d = wdata[W-1:0];
    isr_d  = isr_q;
    if (cmd_we && wdata[DATA_W-1:DATA_W-5] == EOI_TAG)
      isr_d[wdata[IW-1:0]] = 1'b0;
    if (set_we)
      isr_d[set_idx] = 1'b1;
    isr_en = cmd_we | set_we;
  end

  always_comb begin
    blocked[0] = isr_q[0];
    for (int i = 1; i < W; i++) blocked[i] = blocked[i-1] | isr_q[i];
    elig    = req & ~mask_q & ~blocked;
    hit     = |elig;
    hit_idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (elig[i]) hit_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      isr_q  <= '0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (isr_en)  isr_q  <= isr_d;
    end
  end
endmodule

// File: rtl/cic_vector.sv
module cic_vector
  import cic_pkg::*;
(
  input  logic [1:0]       grp,
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  logic [LINE_W-1:0] line;
  always_comb begin
    line = LINE_W'(grp) * LINE_W'(GRP_W) + LINE_W'(idx);
    vec  = VEC_BASE + (VEC_W'(line) << VEC_SHIFT);
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import cic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              int_ack,
  output logic              irq_out,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [NUM_GRP-1:0] g_hit;
  logic [IDX_W-1:0]   g_idx [NUM_GRP];
  logic [GRP_W-1:0]   m_req;
  logic               m_hit;
  logic [IDX_W-1:0]   m_idx;
  logic [1:0]         win_grp;
  logic [IDX_W-1:0]   win_idx;
  logic [VEC_W-1:0]   win_vec;
  logic               irq_q, irq_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic [1:0]         grp_q;
  logic [IDX_W-1:0]   idx_q;
  logic               ack_fire;

  assign ack_fire = int_ack & irq_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slave
    cic_stage #(.W(GRP_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (irq_lines[g*GRP_W +: GRP_W]),
      .mask_we (wr_en && wr_addr == grp_mask_addr(g)),
      .cmd_we  (wr_en && wr_addr == grp_cmd_addr(g)),
      .wdata   (wr_data),
      .set_we  (ack_fire && grp_q == 2'(g)),
      .set_idx (idx_q),
      .hit     (g_hit[g]),
      .hit_idx (g_idx[g])
    );
  end

  always_comb begin
    m_req = '0;
    for (int g = 0; g < NUM_GRP; g++) m_req[casc_input(g)] = g_hit[g];
  end

  cic_stage #(.W(GRP_W)) u_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (m_req),
    .mask_we (wr_en && wr_addr == MST_MASK_A),
    .cmd_we  (wr_en && wr_addr == MST_CMD_A),
    .wdata   (wr_data),
    .set_we  (ack_fire),
    .set_idx (casc_input(int'(grp_q))),
    .hit     (m_hit),
    .hit_idx (m_idx)
  );

  always_comb begin
    win_grp = '0;
    win_idx = g_idx[0];
    for (int g = 0; g < NUM_GRP; g++)
      if (m_idx == casc_input(g)) begin
        win_grp = 2'(g);
        win_idx = g_idx[g];
      end
  end

  cic_vector u_vec (.grp(win_grp), .idx(win_idx), .vec(win_vec));

  always_comb begin
    irq_d = m_hit;
    vec_d = m_hit ? win_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      grp_q <= '0;
      idx_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
      if (m_hit) begin
        grp_q <= win_grp;
        idx_q <= win_idx;
      end
    end
  end

  assign irq_out    = irq_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/cic_checker.sv
module cic_checker
  import cic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [LINES-1:0]  irq_lines,
  input logic              int_ack,
  input logic              irq_out,
  input logic [VEC_W-1:0]  irq_vector
);
  logic [LINES-1:0] lines_prev;
  logic [VEC_W-1:0] line_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_prev <= '0;
    else        lines_prev <= irq_lines;
  end

  assign line_w = (irq_vector - VEC_BASE) >> VEC_SHIFT;

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> irq_vector == '0);  // R4

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_vector[VEC_SHIFT-1:0] == '0 && irq_vector >= VEC_BASE
                 && line_w < VEC_W'(LINES)));  // R4

  AST_LEVEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && line_w < VEC_W'(LINES)) |-> lines_prev[line_w[LINE_W-1:0]]);  // R9

  AST_MASTER_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MST_MASK_A && wr_data == 8'hFF)
      ##1 !(wr_en && wr_addr == MST_MASK_A) |=> !irq_out);  // R8
endmodule

bind casc_irq_ctrl cic_checker u_chk (.*);

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb;
  import cic_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [LINES-1:0]  irq_lines;
  logic              int_ack;
  logic              irq_out;
  logic [VEC_W-1:0]  irq_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0]       m_gmask [3];
  logic [7:0]       m_gisr  [3];
  logic [7:0]       m_mmask;
  logic [7:0]       m_misr;
  logic [LINES-1:0] m_req;

  always #2 clk = ~clk;

  casc_irq_ctrl u_dut (.*);

  function automatic int grp_pick(input int g);
    for (int i = 0; i < 8; i++) begin
      logic blk = 1'b0;
      for (int j = 0; j <= i; j++) blk |= m_gisr[g][j];
      if (m_req[g*8+i] && !m_gmask[g][i] && !blk) return i;
    end
    return -1;
  endfunction

  function automatic int model_line();
    int gi [3];
    for (int g = 0; g < 3; g++) gi[g] = grp_pick(g);
    for (int m = 0; m < 8; m++) begin
      logic blk = 1'b0;
      for (int j = 0; j <= m; j++) blk |= m_misr[j];
      for (int g = 0; g < 3; g++)
        if (int'(casc_input(g)) == m && gi[g] >= 0 && !m_mmask[m] && !blk)
          return g * 8 + gi[g];
    end
    return -1;
  endfunction

  task automatic check_raw(input string tag, input logic e_irq, input logic [VEC_W-1:0] e_vec);
    n_tests++;
    if (irq_out !== e_irq || irq_vector !== e_vec) begin
      n_fail++;
      $display("FAIL %s: irq=%0b vec=%03h expected irq=%0b vec=%03h",
               tag, irq_out, irq_vector, e_irq, e_vec);
    end
  endtask

  task automatic check_model(input string tag);
    int l = model_line();
    if (l < 0) check_raw(tag, 1'b0, '0);
    else       check_raw(tag, 1'b1, VEC_BASE + VEC_W'(l * 16));
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    for (int g = 0; g < 3; g++) begin
      if (a == grp_mask_addr(g)) m_gmask[g] = d;
      if (a == grp_cmd_addr(g) && d[7:3] == 5'b11100) m_gisr[g][d[2:0]] = 1'b0;
    end
    if (a == MST_MASK_A) m_mmask = d;
    if (a == MST_CMD_A && d[7:3] == 5'b11100) m_misr[d[2:0]] = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    model_write(a, d);
    @(negedge clk);
  endtask

  task automatic set_req(input logic [LINES-1:0] v);
    @(negedge clk); irq_lines = v; m_req = v;
    @(negedge clk);
  endtask

  task automatic ack();
    int l = model_line();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    if (l >= 0) begin
      m_gisr[l/8][l%8] = 1'b1;
      m_misr[casc_input(l/8)] = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_lines = '0; int_ack = 1'b0;
    for (int g = 0; g < 3; g++) begin m_gmask[g] = 8'hFF; m_gisr[g] = '0; end
    m_mmask = 8'hFF; m_misr = '0; m_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_raw("R1 reset outputs", 1'b0, '0);
    set_req('1); @(negedge clk);
    check_raw("R1 all masked after reset", 1'b0, '0);
    set_req('0);

    // R11: unmapped addresses must not open anything
    wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'hA, 8'h00);
    set_req('1); @(negedge clk);
    check_raw("R11 unmapped writes ignored", 1'b0, '0);
    set_req('0);

    // R8: open cascades, then every group
    wr(MST_MASK_A, 8'h44);
    for (int g = 0; g < 3; g++) wr(grp_mask_addr(g), 8'h00);

    // R10: request seen one edge later
    @(negedge clk); irq_lines = 24'h000020; m_req = irq_lines;
    @(negedge clk);
    check_raw("R10 request after one edge", 1'b1, 12'h850);
    check_raw("R4 vector line 5", 1'b1, 12'h850);

    // R10: mask write lands after two edges
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'h3; wr_data = 8'h20;
    @(negedge clk); wr_en = 1'b0; model_write(4'h3, 8'h20);
    check_raw("R10 old value one edge after mask write", 1'b1, 12'h850);
    @(negedge clk);
    check_raw("R10 masked two edges after write", 1'b0, '0);
    wr(4'h3, 8'h00);

    set_req(24'h100200);
    check_raw("R3 line 9 beats line 20", 1'b1, 12'h890);
    wr(4'h7, 8'h02);
    check_raw("R2 group 1 mask bit 1 hides line 9", 1'b1, 12'h940);
    wr(4'h7, 8'h00);
    set_req(24'h000200);
    check_raw("R9 dropped line 20 absent", 1'b1, 12'h890);
    set_req(24'h000000);
    check_raw("R9 no request", 1'b0, '0);

    // R5/R6/R7 nesting
    set_req(24'h001408);
    check_raw("R3 line 3 wins", 1'b1, 12'h830);
    ack();
    check_raw("R6 group 0 in service blocks all", 1'b0, '0);
    wr(4'h2, 8'h63);
    check_raw("R7 non-EOI command ignored", 1'b0, '0);
    wr(4'h2, 8'hE3);
    check_raw("R7 slave EOI alone keeps master blocked", 1'b0, '0);
    wr(MST_CMD_A, 8'hE1);
    check_raw("R7 full EOI releases line 3", 1'b1, 12'h830);
    set_req(24'h001400);
    check_raw("R3 line 10 next", 1'b1, 12'h8A0);
    ack();
    check_raw("R5 line 10 blocks line 12 in group", 1'b0, '0);
    set_req(24'h001410);
    check_raw("R6 group 0 nests above group 1", 1'b1, 12'h840);
    set_req(24'h000000);
    wr(4'h6, 8'hE2); wr(MST_CMD_A, 8'hE3);
    check_model("R7 cleanup");
    wr(MST_MASK_A, 8'hFF);
    set_req(24'hFFFFFF);
    check_raw("R8 master mask 0xFF silences all", 1'b0, '0);
    wr(MST_MASK_A, 8'h44);
    check_raw("R8 0x44 reopens cascades", 1'b1, 12'h800);

    // R3: random mix against the model
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 8;
      int g  = $urandom % 3;
      case (op)
        0, 1: set_req(LINES'($urandom));
        2: wr(grp_mask_addr(g), 8'($urandom & $urandom));
        3: wr(MST_MASK_A, ($urandom % 3 == 0) ? 8'($urandom) : 8'h44);
        4, 5: ack();
        6: begin
          wr(grp_cmd_addr(g), 8'hE0 | 8'($urandom % 8));
          wr(MST_CMD_A, 8'hE0 | 8'(casc_input(g)));
        end
        default: wr(4'($urandom), {3'b0, 5'($urandom)});
      endcase
      check_model("R3 random against model");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule